// File: doc/BRIEF.md
# Multi-Mode Lattice Coefficient Sampler

This block turns a stream of 32-bit uniformly random words into polynomial coefficients for lattice cryptography. It supports four distributions: uniform modulo q with rejection, bounded uniform over a symmetric range, centred binomial, and trinary. Random words enter on a valid/ready port. Coefficients leave on a second valid/ready port and are already reduced into [0, q).

Each accepted word is loaded into a bit buffer. The buffer is then cut into fixed-width chunks, starting at the least significant bit. The mode sets the chunk width. One chunk is tried per clock cycle. A chunk either yields one coefficient or is rejected and yields nothing. Chunks never span two words: any bits left over that are too few for a whole chunk are dropped when the next word is loaded.

The mode, modulus and range settings are quasi-static. They may only change while reset is asserted.

Top module: `sampler_top`

## Requirements
- R1: After reset, `in_ready` is high exactly when fewer unused bits remain in the buffer than the chunk width. An accepted word replaces the buffer completely, and any leftover bits are discarded. Chunks are taken from the least significant bit upward, one chunk per cycle in which the output can accept a result.
- R2: Uniform mode (`cfg_mode` = 0) uses chunks of `cfg_qbits` bits. A chunk c is emitted as c when c < q and is dropped otherwise.
- R3: Bounded mode (`cfg_mode` = 1) uses chunks of `cfg_tbits` bits. A chunk c with c <= 2*theta yields the sample c - theta. Larger chunks are dropped.
- R4: Binomial mode (`cfg_mode` = 2) uses chunks of 2*tau bits, with 1 <= tau <= 16. The sample is the number of ones in the low tau bits minus the number of ones in the next tau bits.
- R5: Trinary mode (`cfg_mode` = 3) uses 2-bit chunks. Code 00 gives 0, code 01 gives +1, code 10 gives -1, and code 11 is dropped.
- R6: A negative sample v is emitted as q + v, so every emitted coefficient lies in [0, q). This assumes q > 2*theta and q > tau.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. Coefficients leave in the order their chunks appear.
- R8: In binomial and trinary mode, with the output never stalled, a word keeps `in_ready` low for exactly floor(32 / chunk width) cycles after it is accepted, whatever its bit values.
- R9: While reset is asserted and in the cycle after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Distribution select: 0 uniform, 1 bounded, 2 binomial, 3 trinary |
| cfg_q | input | COEF_W | Modulus q |
| cfg_qbits | input | $clog2(COEF_W+1) | Chunk width in uniform mode |
| cfg_theta | input | COEF_W | Bound theta for bounded mode |
| cfg_tbits | input | $clog2(COEF_W+1) | Chunk width in bounded mode |
| cfg_tau | input | $clog2(MAX_TAU+1) | Binomial parameter tau |
| in_valid | input | 1 | Random word available |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | WORD_W | Random word |
| out_valid | output | 1 | Coefficient available |
| out_ready | input | 1 | Consumer takes the coefficient |
| out_data | output | COEF_W | Coefficient in [0, q) |

## Verification
The bench builds the block with its defaults: 32-bit words, 24-bit coefficients and tau up to 16. It runs with q = 3329 and a 12-bit uniform chunk. At that setting the exact rejection boundary (3328 kept, 3329 dropped) can be hit, and so can the dropping of the top 8 leftover bits of each word. A full 32-bit binomial chunk (tau = 16) reaches both extremes, +16 and q - 16. Bounded mode with theta = 5 and 4-bit chunks covers both rejection and negative wrap-around. Random backpressure on the output exercises stall holding, and fixed all-zero and all-one words check that trinary and binomial timing does not depend on the data.

// File: rtl/sampler_pkg.sv
package sampler_pkg;
  typedef enum logic [1:0] {
    MODE_UNIF  = 2'd0,
    MODE_BOUND = 2'd1,
    MODE_BINOM = 2'd2,
    MODE_TRIN  = 2'd3
  } smp_mode_e;
endpackage

// File: rtl/sampler_bitbuf.sv
module sampler_bitbuf #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  need,
  input  logic              take,
  output logic [WORD_W-1:0] chunk,
  output logic              have
);
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  left_q;

  assign in_ready = (left_q < need);
  assign have     = !in_ready;
  assign chunk    = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      left_q <= '0;
    end else if (in_valid && in_ready) begin
      word_q <= in_data;
      left_q <= CNT_W'(WORD_W);
    end else if (take) begin
      word_q <= word_q >> need;
      left_q <= left_q - need;
    end
  end
endmodule

// File: rtl/sampler_map.sv
module sampler_map
  import sampler_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int COEF_W  = 24,
  parameter int MAX_TAU = 16,
  parameter int CNT_W   = $clog2(WORD_W + 1),
  parameter int QB_W    = $clog2(COEF_W + 1),
  parameter int TAU_W   = $clog2(MAX_TAU + 1)
) (
  input  smp_mode_e         mode,
  input  logic [COEF_W-1:0] q,
  input  logic [QB_W-1:0]   qbits,
  input  logic [COEF_W-1:0] theta,
  input  logic [QB_W-1:0]   tbits,
  input  logic [TAU_W-1:0]  tau,
  input  logic [WORD_W-1:0] chunk,
  output logic [CNT_W-1:0]  need,
  output logic              accept,
  output logic [COEF_W-1:0] coef
);
  localparam int SV_W = COEF_W + 2;

  logic [WORD_W:0]    mask_w;
  logic [COEF_W-1:0]  cand;
  logic [MAX_TAU-1:0] hi;
  logic [TAU_W-1:0]   ones_lo, ones_hi;
  logic [SV_W-1:0]    sv, wrapped;

  always_comb begin
    case (mode)
      MODE_UNIF:  need = CNT_W'(qbits);
      MODE_BOUND: need = CNT_W'(tbits);
      MODE_BINOM: need = CNT_W'({tau, 1'b0});
      default:    need = CNT_W'(2);
    endcase
  end

  assign mask_w = ((WORD_W+1)'(1) << need) - (WORD_W+1)'(1);
  assign cand   = COEF_W'(chunk & mask_w[WORD_W-1:0]);
  assign hi     = MAX_TAU'(chunk >> tau);

  always_comb begin
    ones_lo = '0;
    ones_hi = '0;
    for (int i = 0; i < MAX_TAU; i++) begin
      if (i < int'(tau)) begin
        ones_lo = ones_lo + TAU_W'(chunk[i]);
        ones_hi = ones_hi + TAU_W'(hi[i]);
      end
    end
  end

  always_comb begin
    accept = 1'b1;
    sv     = '0;
    case (mode)
      MODE_UNIF: begin
        accept = (cand < q);
        sv     = {2'b00, cand};
      end
      MODE_BOUND: begin
        accept = ({1'b0, cand} <= {theta, 1'b0});
        sv     = {2'b00, cand} - {2'b00, theta};
      end
      MODE_BINOM: sv = SV_W'(ones_lo) - SV_W'(ones_hi);
      default: begin
        case (chunk[1:0])
          2'b00:   sv = '0;
          2'b01:   sv = SV_W'(1);
          2'b10:   sv = '1;
          default: accept = 1'b0;
        endcase
      end
    endcase
  end

  assign wrapped = sv[SV_W-1] ? ({2'b00, q} + sv) : sv;
  assign coef    = wrapped[COEF_W-1:0];
endmodule

// File: rtl/sampler_top.sv
module sampler_top
  import sampler_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int COEF_W  = 24,
  parameter int MAX_TAU = 16,
  localparam int CNT_W  = $clog2(WORD_W + 1),
  localparam int QB_W   = $clog2(COEF_W + 1),
  localparam int TAU_W  = $clog2(MAX_TAU + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [COEF_W-1:0] cfg_q,
  input  logic [QB_W-1:0]   cfg_qbits,
  input  logic [COEF_W-1:0] cfg_theta,
  input  logic [QB_W-1:0]   cfg_tbits,
  input  logic [TAU_W-1:0]  cfg_tau,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COEF_W-1:0] out_data
);
  logic [CNT_W-1:0]  need;
  logic [WORD_W-1:0] chunk;
  logic              have, fire, accept;
  logic [COEF_W-1:0] coef;

  assign fire = have && (!out_valid || out_ready);

  sampler_bitbuf #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_bitbuf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .need(need), .take(fire), .chunk(chunk), .have(have)
  );

  sampler_map #(.WORD_W(WORD_W), .COEF_W(COEF_W), .MAX_TAU(MAX_TAU),
                .CNT_W(CNT_W), .QB_W(QB_W), .TAU_W(TAU_W)) i_map (
    .mode(smp_mode_e'(cfg_mode)), .q(cfg_q), .qbits(cfg_qbits),
    .theta(cfg_theta), .tbits(cfg_tbits), .tau(cfg_tau), .chunk(chunk),
    .need(need), .accept(accept), .coef(coef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire && accept) begin
        out_valid <= 1'b1;
        out_data  <= coef;
      end
    end
  end
endmodule

// File: rtl/sampler_checker.sv
module sampler_checker #(
  parameter int COEF_W = 24,
  parameter int TAU_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_mode,
  input logic [COEF_W-1:0] cfg_q,
  input logic [COEF_W-1:0] cfg_theta,
  input logic [TAU_W-1:0]  cfg_tau,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [COEF_W-1:0] out_data
);
  AST_OUT_BELOW_Q: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data < cfg_q); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_TRIN_SET: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_mode == 2'd3 |->
      (out_data == '0 || out_data == COEF_W'(1) || out_data == cfg_q - COEF_W'(1))); // R5

  AST_BINOM_SPAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_mode == 2'd2 |->
      (out_data <= COEF_W'(cfg_tau) || out_data >= cfg_q - COEF_W'(cfg_tau))); // R4

  AST_BOUND_SPAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_mode == 2'd1 |->
      (out_data <= cfg_theta || out_data >= cfg_q - cfg_theta)); // R3

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && in_ready); // R9
endmodule

bind sampler_top sampler_checker #(.COEF_W(COEF_W), .TAU_W(TAU_W)) i_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_q(cfg_q),
  .cfg_theta(cfg_theta), .cfg_tau(cfg_tau), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/test_sampler_top.sv
module test_sampler_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32, COEF_W = 24, MAX_TAU = 16;
  localparam int QB_W = $clog2(COEF_W + 1), TAU_W = $clog2(MAX_TAU + 1);

  logic clk = 0, rst = 1;
  logic [1:0] cfg_mode = 0;
  logic [COEF_W-1:0] cfg_q = 0, cfg_theta = 0;
  logic [QB_W-1:0] cfg_qbits = 1, cfg_tbits = 1;
  logic [TAU_W-1:0] cfg_tau = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [WORD_W-1:0] in_data = 0;
  logic [COEF_W-1:0] out_data;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string cur_tag = "R2";
  bit bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 0;
  logic [COEF_W-1:0] prev_data = 0;
  logic [31:0] seed = 32'h1234_5678;

  sampler_top #(.WORD_W(WORD_W), .COEF_W(COEF_W), .MAX_TAU(MAX_TAU)) i_sampler_top (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_q(cfg_q), .cfg_qbits(cfg_qbits),
    .cfg_theta(cfg_theta), .cfg_tbits(cfg_tbits), .cfg_tau(cfg_tau),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  // consumer: compares every handshake against the reference queue
  always @(negedge clk) begin
    if (rst) prev_stall = 0;
    else begin
      if (prev_stall) check(out_valid && out_data == prev_data, "R7 hold", out_data, prev_data);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, {cur_tag, " unexpected"}, out_data, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(out_data == COEF_W'(e), cur_tag, out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  function automatic int wrapq(int v);
    return (v < 0) ? int'(cfg_q) + v : v;
  endfunction

  task automatic model_word(logic [31:0] w);
    int k, q, th, tau;
    q = int'(cfg_q); th = int'(cfg_theta); tau = int'(cfg_tau);
    case (cfg_mode)
      2'd0: k = int'(cfg_qbits);
      2'd1: k = int'(cfg_tbits);
      2'd2: k = 2 * tau;
      default: k = 2;
    endcase
    for (int off = 0; off + k <= 32; off += k) begin
      longint c;
      c = (longint'(w) >> off) & ((64'd1 << k) - 1);
      case (cfg_mode)
        2'd0: if (c < q) exp_q.push_back(int'(c));
        2'd1: if (c <= 2 * th) exp_q.push_back(wrapq(int'(c) - th));
        2'd2: begin
          int a, b;
          a = 0; b = 0;
          for (int i = 0; i < tau; i++) begin
            a += int'((c >> i) & 1);
            b += int'((c >> (tau + i)) & 1);
          end
          exp_q.push_back(wrapq(a - b));
        end
        default: case (c)
          0: exp_q.push_back(0);
          1: exp_q.push_back(1);
          2: exp_q.push_back(q - 1);
          default: ;
        endcase
      endcase
    end
  endtask

  task automatic setup(int mode, int q, int qb, int th, int tb, int tau, bit bp);
    @(negedge clk);
    rst = 1; bp_en = bp;
    cfg_mode = 2'(mode); cfg_q = COEF_W'(q); cfg_qbits = QB_W'(qb);
    cfg_theta = COEF_W'(th); cfg_tbits = QB_W'(tb); cfg_tau = TAU_W'(tau);
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic send(logic [31:0] w);
    bit hs;
    model_word(w);
    in_valid = 1; in_data = w;
    forever begin
      hs = in_ready;
      @(posedge clk); @(negedge clk);
      if (hs) break;
    end
    in_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 2000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, {cur_tag, " drain"}, exp_q.size(), 0);
  endtask

  task automatic send_random(int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      send(seed);
    end
  endtask

  task automatic t_reset();
    setup(0, 3329, 12, 0, 1, 1, 0);
    check(out_valid == 0, "R9 out_valid", out_valid, 0);
    check(in_ready == 1, "R9 in_ready", in_ready, 1);
  endtask

  task automatic t_uniform();
    cur_tag = "R2 uniform";
    setup(0, 3329, 12, 0, 1, 1, 0);
    send(32'h00D0_0D01);  // 3329 rejected, 3328 kept, top byte dropped (R1)
    send(32'hFF10_0FFF);  // 4095 rejected, 256 kept
    drain();
    bp_en = 1; cur_tag = "R7 uniform stalled";
    send_random(40);
    drain();
  endtask

  task automatic t_bounded();
    cur_tag = "R3 bounded";
    setup(1, 3329, 12, 5, 4, 1, 1);
    send(32'hFA98_5210);
    send_random(30);
    drain();
  endtask

  task automatic t_binom();
    cur_tag = "R4 binomial tau16";
    setup(2, 3329, 12, 0, 1, 16, 0);
    send(32'hFFFF_0000);  // -16 -> q-16 (R6)
    send(32'h0000_FFFF);  // +16
    send_random(20);
    drain();
    cur_tag = "R4 binomial tau3";
    setup(2, 17, 12, 0, 1, 3, 1);
    send_random(30);
    drain();
  endtask

  task automatic t_trinary();
    cur_tag = "R5 trinary";
    setup(3, 3329, 12, 0, 1, 1, 1);
    send(32'hE4E4_E4E4);  // 00,01,10,11 repeated
    send_random(30);
    drain();
  endtask

  task automatic timing_one(logic [31:0] w, int expc, string tag);
    int cnt = 0;
    send(w);
    while (!in_ready && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == expc, tag, cnt, expc);
  endtask

  task automatic t_timing();
    cur_tag = "R8 trinary";
    setup(3, 3329, 12, 0, 1, 1, 0);
    timing_one(32'h0000_0000, 16, "R8 trinary zeros");
    timing_one(32'hFFFF_FFFF, 16, "R8 trinary ones");
    drain();
    cur_tag = "R8 binomial";
    setup(2, 3329, 12, 0, 1, 4, 0);
    timing_one(32'h0000_0000, 4, "R8 binomial zeros");
    timing_one(32'hFFFF_FFFF, 4, "R8 binomial ones");
    drain();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_uniform();
    t_bounded();
    t_binom();
    t_trinary();
    t_timing();
    finish_run();
  end
endmodule